// File: doc/BRIEF.md
# Serial flash command engine

This block is the decoding core of a serial flash slave. It watches the SPI lines, which are sampled by the system clock, and assembles each instruction from the serial input, MSB first. It then does one of three things. For read-type instructions it shifts bytes out on the serial output. For program and erase instructions it raises a one-cycle request to a synchronous memory port. For write-enable, write-disable, status-arm and status-write instructions it sends a one-cycle event to a separate status unit.

The status unit gives back the write-enable latch, the two-bit protection level and the status byte. The memory port takes a request together with an operation code, an address and a data byte, and it answers later with a done pulse. Read data comes back from a registered lookup one clock after the read address is presented. The serial clock must stay at least four system clocks high and four system clocks low.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, spi_miso_oe, mem_req, seq_mode, seq_end and all event outputs are 0.
- R2: Opcode 03h plus a three-byte address returns the bytes at consecutive addresses, starting at the given address, for as long as the select stays low. Each bit changes after a falling serial clock edge. spi_miso_oe is 1 only while data is being shifted out, and it drops when the select goes high.
- R3: A read that passes the top address (all AW bits set) continues at address 0.
- R4: Opcode 05h repeats stat_byte on every following byte until the select rises.
- R5: Opcode 90h or ABh plus a three-byte address returns BFh and DEV_ID in alternation. The output starts with BFh when address bit 0 is 0 and with DEV_ID when it is 1.
- R6: A single-byte 06h, 04h or 50h pulses ev_wr_on, ev_wr_off or ev_stat_arm respectively. The two-byte 01h+data pulses ev_stat_wr and presents the data on stat_wr_data. Each of these acts only on a select rise that follows exactly that many whole bytes.
- R7: Opcode 02h plus address plus data issues mem_op 0 (program) at that address with that data, on the select rise after exactly five bytes. It does this only when wr_latch is 1.
- R8: The protection level selects what is locked: 0 locks nothing, 1 locks the top quarter, 2 locks the top half and 3 locks everything. A program or erase that targets a locked address is not issued. Opcode 60h issues mem_op 3 (chip erase) only when the level is 0 and wr_latch is 1.
- R9: Opcode 20h issues mem_op 1 with address bits below SECTOR_BITS cleared. Opcode 52h issues mem_op 2 with bits below BLOCK_BITS cleared.
- R10: Opcode AFh plus address plus data programs that address and sets seq_mode. While seq_mode is 1, a two-byte AFh+data programs the next sequential address. A write-disable clears seq_mode.
- R11: When sequential programming writes the top address, seq_mode clears and seq_end pulses. There is no wrap-around, and a later two-byte AFh issues nothing.
- R12: A select rise that falls inside a byte executes nothing.
- R13: From a request until its done pulse, every command except 05h is ignored, and no second request is issued.
- R14: SPI mode 3 (clock idling high) works the same as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock |
| spi_sel_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| wr_latch | input | 1 | Write-enable latch from the status unit |
| prot_lvl | input | 2 | Protection level from the status unit |
| stat_byte | input | 8 | Status byte returned by 05h |
| ev_wr_on | output | 1 | Write-enable event |
| ev_wr_off | output | 1 | Write-disable event |
| ev_stat_arm | output | 1 | Status-arm event |
| ev_stat_wr | output | 1 | Status-write event |
| stat_wr_data | output | 8 | Data carried by the status-write event |
| seq_mode | output | 1 | Sequential programming mode is active |
| seq_end | output | 1 | Pulse: sequential mode ended at the top address |
| mem_req | output | 1 | Memory request pulse |
| mem_op | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 8 | Program data |
| mem_done | input | 1 | Completion pulse from the memory |
| rd_addr | output | AW | Read lookup address |
| rd_data | input | 8 | Read data, one clock after rd_addr |

## Verification
Reads are tried at a mid-array address and just below the top, which separates plain address increment from wrap-around. The mode 3 run separates clock-polarity handling from the bit timing. Every protection level is swept against an address in each quarter, so an off-by-one in the locked region shows up as a wrong request. Sequential programming is driven both to a write-disable and to the top address, which separates the two ways the mode can end. Truncated frames, over-long frames and commands sent while a request is still outstanding test that nothing executes from them.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    typedef enum logic [7:0] {
        OP_READ     = 8'h03,
        OP_PROG     = 8'h02,
        OP_SEQ_PROG = 8'hAF,
        OP_SECTOR   = 8'h20,
        OP_BLOCK    = 8'h52,
        OP_CHIP     = 8'h60,
        OP_STAT_RD  = 8'h05,
        OP_WR_ON    = 8'h06,
        OP_WR_OFF   = 8'h04,
        OP_STAT_ARM = 8'h50,
        OP_STAT_WR  = 8'h01,
        OP_ID_A     = 8'h90,
        OP_ID_B     = 8'hAB
    } opcode_e;

    typedef enum logic [1:0] {
        MEM_PROG   = 2'd0,
        MEM_SECTOR = 2'd1,
        MEM_BLOCK  = 2'd2,
        MEM_CHIP   = 2'd3
    } mem_op_e;

    typedef struct packed {
        logic       done;
        logic [2:0] idx;
        logic [7:0] data;
    } rx_byte_t;

    localparam logic [7:0] MFR_ID = 8'hBF;

    // top2 = two most significant address bits
    function automatic logic region_locked(input logic [1:0] lvl, input logic [1:0] top2);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return top2 == 2'b11;
            2'd2:    return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/flash_spi_rx.sv
`timescale 1ns/1ps
module flash_spi_rx
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_clk,
    input  logic       spi_sel_n,
    input  logic       spi_mosi,
    output logic       sck_fall,
    output logic       sel_rise,
    output rx_byte_t   rx,
    output logic [2:0] bit_cnt,
    output logic [2:0] byte_cnt
);
    logic       sck_q, sel_q, sck_rise;
    logic [6:0] sh;

    assign sck_rise = spi_clk & ~sck_q & ~spi_sel_n;
    assign sck_fall = ~spi_clk & sck_q & ~spi_sel_n;
    assign sel_rise = spi_sel_n & ~sel_q;

    always_ff @(posedge clk) begin
        rx.done <= 1'b0;
        if (rst) begin
            sck_q    <= 1'b0;
            sel_q    <= 1'b1;
            sh       <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx       <= '0;
        end else begin
            sck_q <= spi_clk;
            sel_q <= spi_sel_n;
            if (spi_sel_n) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
            end else if (sck_rise) begin
                sh      <= {sh[5:0], spi_mosi};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx.done <= 1'b1;
                    rx.data <= {sh, spi_mosi};
                    rx.idx  <= byte_cnt;
                    if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
                end
            end
        end
    end
endmodule

// File: rtl/flash_spi_tx.sv
`timescale 1ns/1ps
module flash_spi_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_fall,
    input  logic       en,
    input  logic [7:0] src,
    output logic       load,
    output logic       miso,
    output logic       oe
);
    logic [2:0] cnt;
    logic [7:0] sh;

    assign load = en & sck_fall & (cnt == 3'd0);
    assign miso = sh[7];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            sh  <= '0;
            oe  <= 1'b0;
        end else if (sck_fall) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd0) begin
                sh <= src;
                oe <= 1'b1;
            end else begin
                sh <= {sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int         AW          = 19,
    parameter int         SECTOR_BITS = 12,
    parameter int         BLOCK_BITS  = 15,
    parameter logic [7:0] DEV_ID      = 8'h44
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          spi_clk,
    input  logic          spi_sel_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    input  logic          wr_latch,
    input  logic [1:0]    prot_lvl,
    input  logic [7:0]    stat_byte,
    output logic          ev_wr_on,
    output logic          ev_wr_off,
    output logic          ev_stat_arm,
    output logic          ev_stat_wr,
    output logic [7:0]    stat_wr_data,
    output logic          seq_mode,
    output logic          seq_end,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_done,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};
    localparam logic [AW-1:0] SEC_MASK = TOP_ADDR << SECTOR_BITS;
    localparam logic [AW-1:0] BLK_MASK = TOP_ADDR << BLOCK_BITS;

    function automatic logic locked(input logic [1:0] lvl, input logic [AW-1:0] a);
        return region_locked(lvl, a[AW-1 -: 2]);
    endfunction

    logic          sck_fall, sel_rise, tx_load, exec, fire;
    logic [2:0]    bit_cnt, byte_cnt;
    rx_byte_t      rx;
    opcode_e       op_q;
    logic          skip_q, out_q, seq_q, inflight, id_alt;
    logic [AW-1:0] addr_q, ptr_q, seq_ptr, f_addr;
    logic [7:0]    data_q, tx_src;
    mem_op_e       f_op, mem_op_q;

    flash_spi_rx u_rx (
        .clk, .rst, .spi_clk, .spi_sel_n, .spi_mosi,
        .sck_fall, .sel_rise, .rx, .bit_cnt, .byte_cnt
    );

    flash_spi_tx u_tx (
        .clk, .rst, .sck_fall,
        .en   (out_q & ~spi_sel_n),
        .src  (tx_src),
        .load (tx_load),
        .miso (spi_miso),
        .oe   (spi_miso_oe)
    );

    always_comb begin
        case (op_q)
            OP_READ:    tx_src = rd_data;
            OP_STAT_RD: tx_src = stat_byte;
            default:    tx_src = id_alt ? DEV_ID : MFR_ID;
        endcase
    end

    // Commands act only on a select rise on a byte boundary
    assign exec = sel_rise && (bit_cnt == 3'd0) && !skip_q;

    always_comb begin
        fire   = 1'b0;
        f_op   = MEM_PROG;
        f_addr = addr_q;
        if (exec) begin
            case (op_q)
                OP_PROG:
                    fire = (byte_cnt == 3'd5) && wr_latch && !locked(prot_lvl, addr_q);
                OP_SEQ_PROG: begin
                    if (seq_q && byte_cnt == 3'd2) f_addr = seq_ptr;
                    fire = wr_latch && !locked(prot_lvl, f_addr) &&
                           ((seq_q && byte_cnt == 3'd2) || byte_cnt == 3'd5);
                end
                OP_SECTOR: begin
                    f_op   = MEM_SECTOR;
                    f_addr = addr_q & SEC_MASK;
                    fire   = (byte_cnt == 3'd4) && wr_latch && !locked(prot_lvl, f_addr);
                end
                OP_BLOCK: begin
                    f_op   = MEM_BLOCK;
                    f_addr = addr_q & BLK_MASK;
                    fire   = (byte_cnt == 3'd4) && wr_latch && !locked(prot_lvl, f_addr);
                end
                OP_CHIP: begin
                    f_op   = MEM_CHIP;
                    f_addr = '0;
                    fire   = (byte_cnt == 3'd1) && wr_latch && (prot_lvl == 2'd0);
                end
                default: fire = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        mem_req     <= 1'b0;
        ev_wr_on    <= 1'b0;
        ev_wr_off   <= 1'b0;
        ev_stat_arm <= 1'b0;
        ev_stat_wr  <= 1'b0;
        seq_end     <= 1'b0;
        if (rst) begin
            op_q         <= OP_READ;
            skip_q       <= 1'b0;
            out_q        <= 1'b0;
            seq_q        <= 1'b0;
            inflight     <= 1'b0;
            id_alt       <= 1'b0;
            addr_q       <= '0;
            ptr_q        <= '0;
            seq_ptr      <= '0;
            data_q       <= '0;
            stat_wr_data <= '0;
            mem_op_q     <= MEM_PROG;
            mem_addr     <= '0;
            mem_wdata    <= '0;
        end else begin
            if (mem_done) inflight <= 1'b0;
            if (spi_sel_n) out_q <= 1'b0;
            if (rx.done) begin
                data_q <= rx.data;
                if (rx.idx == 3'd0) begin
                    op_q   <= opcode_e'(rx.data);
                    skip_q <= inflight && (rx.data != OP_STAT_RD);
                    out_q  <= (rx.data == OP_STAT_RD);
                end else if (rx.idx <= 3'd3) begin
                    addr_q <= {addr_q[AW-9:0], rx.data};
                    if (rx.idx == 3'd3 && !skip_q &&
                        (op_q == OP_READ || op_q == OP_ID_A || op_q == OP_ID_B)) begin
                        out_q  <= 1'b1;
                        ptr_q  <= {addr_q[AW-9:0], rx.data};
                        id_alt <= rx.data[0];
                    end
                end
            end
            if (tx_load) begin
                ptr_q  <= ptr_q + 1'b1;
                id_alt <= ~id_alt;
            end
            if (exec) begin
                case (op_q)
                    OP_WR_ON:    ev_wr_on    <= (byte_cnt == 3'd1);
                    OP_STAT_ARM: ev_stat_arm <= (byte_cnt == 3'd1);
                    OP_WR_OFF: if (byte_cnt == 3'd1) begin
                        ev_wr_off <= 1'b1;
                        seq_q     <= 1'b0;
                    end
                    OP_STAT_WR: if (byte_cnt == 3'd2) begin
                        ev_stat_wr   <= 1'b1;
                        stat_wr_data <= data_q;
                    end
                    default: ;
                endcase
            end
            if (fire) begin
                mem_req   <= 1'b1;
                mem_op_q  <= f_op;
                mem_addr  <= f_addr;
                mem_wdata <= data_q;
                inflight  <= 1'b1;
                if (op_q == OP_SEQ_PROG) begin
                    seq_ptr <= f_addr + 1'b1;
                    if (f_addr == TOP_ADDR) begin
                        seq_q   <= 1'b0;
                        seq_end <= 1'b1;
                    end else begin
                        seq_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign mem_op   = mem_op_q;
    assign seq_mode = seq_q;
    assign rd_addr  = ptr_q;
endmodule

// File: rtl/flash_cmd_engine_chk.sv
`timescale 1ns/1ps
module flash_cmd_engine_chk
    import flash_cmd_pkg::*;
#(
    parameter int AW          = 19,
    parameter int SECTOR_BITS = 12,
    parameter int BLOCK_BITS  = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          spi_clk,
    input logic          spi_sel_n,
    input logic          spi_miso,
    input logic          spi_miso_oe,
    input logic [1:0]    prot_lvl,
    input logic          ev_wr_on,
    input logic          ev_wr_off,
    input logic          ev_stat_arm,
    input logic          ev_stat_wr,
    input logic          seq_mode,
    input logic          seq_end,
    input logic          mem_req,
    input logic [1:0]    mem_op,
    input logic [AW-1:0] mem_addr,
    input logic          mem_done
);
    logic busy_c;
    always_ff @(posedge clk) begin
        if (rst)           busy_c <= 1'b0;
        else if (mem_req)  busy_c <= 1'b1;
        else if (mem_done) busy_c <= 1'b0;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !mem_req && !spi_miso_oe && !seq_mode);

    a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
        spi_sel_n && $past(spi_sel_n) |-> !spi_miso_oe);

    a_r2_miso_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        spi_miso_oe && $past(spi_miso_oe) && !(!$past(spi_clk) && $past(spi_clk, 2))
        |-> $stable(spi_miso));

    a_r6_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_wr_on, ev_wr_off, ev_stat_arm, ev_stat_wr}));

    a_r12_req_on_deselect: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $past(spi_sel_n) && !$past(spi_sel_n, 2));

    a_r9_sector_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_op == MEM_SECTOR |-> mem_addr[SECTOR_BITS-1:0] == '0);

    a_r9_block_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_op == MEM_BLOCK |-> mem_addr[BLOCK_BITS-1:0] == '0);

    a_r8_chip_needs_open: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_op == MEM_CHIP |-> $past(prot_lvl) == 2'd0);

    a_r11_end_leaves_mode: assert property (@(posedge clk) disable iff (rst)
        seq_end |-> !seq_mode);

    a_r13_single_flight: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !busy_c);
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(
    .AW(AW), .SECTOR_BITS(SECTOR_BITS), .BLOCK_BITS(BLOCK_BITS)
) u_chk (.*);

// File: tb/flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb;
    localparam int AW = 16;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          sck = 1'b0, sel_n = 1'b1, mosi = 1'b0;
    logic          miso, miso_oe;
    logic          wel = 1'b1;
    logic [1:0]    lvl = 2'd0;
    logic [7:0]    stat = 8'hA5;
    logic          ev_on, ev_off, ev_arm, ev_swr, seq_mode, seq_end, mem_req, mem_done = 1'b0;
    logic [7:0]    swr_data, mem_wdata, rd_data;
    logic [1:0]    mem_op;
    logic [AW-1:0] mem_addr, rd_addr;

    flash_cmd_engine #(.AW(AW)) u_dut (
        .clk, .rst, .spi_clk(sck), .spi_sel_n(sel_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .wr_latch(wel), .prot_lvl(lvl),
        .stat_byte(stat), .ev_wr_on(ev_on), .ev_wr_off(ev_off), .ev_stat_arm(ev_arm),
        .ev_stat_wr(ev_swr), .stat_wr_data(swr_data), .seq_mode, .seq_end,
        .mem_req, .mem_op, .mem_addr, .mem_wdata, .mem_done, .rd_addr, .rd_data
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    always @(posedge clk) rd_data <= pat(rd_addr);

    int n_tests = 0, n_fail = 0;
    int req_cnt = 0, n_on = 0, n_off = 0, n_arm = 0, n_swr = 0, n_end = 0;
    logic [1:0]  last_op;
    logic [15:0] last_addr;
    logic [7:0]  last_data, last_swr;
    int lat = 30, dcnt = 0;
    bit mode3 = 1'b0;

    always @(negedge clk) begin
        if (mem_req) begin
            req_cnt++; last_op = mem_op; last_addr = mem_addr; last_data = mem_wdata;
            dcnt = lat;
        end else if (dcnt > 0) dcnt--;
        mem_done = (dcnt == 1);
        if (ev_on) n_on++;
        if (ev_off) n_off++;
        if (ev_arm) n_arm++;
        if (ev_swr) begin n_swr++; last_swr = swr_data; end
        if (seq_end) n_end++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            @(negedge clk); sck = 1'b0; mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic sel();
        @(negedge clk); sck = mode3; repeat (4) @(negedge clk);
        sel_n = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk); if (!mode3) sck = 1'b0;
        repeat (4) @(negedge clk); sel_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_addr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] d;
        xbyte(op, d); xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xbyte(op, d); desel();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] v);
        logic [7:0] d;
        sel(); xbyte(op, d); xbyte(v, d); desel();
    endtask

    task automatic cmd_ad(input logic [7:0] op, input logic [23:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel(); send_addr(op, a); xbyte(v, d); desel();
    endtask

    task automatic cmd_a(input logic [7:0] op, input logic [23:0] a);
        sel(); send_addr(op, a); desel();
    endtask

    task automatic wait_done();
        repeat (lat + 20) @(negedge clk);
    endtask

    task automatic read_run(input logic [15:0] a0, input int nb, input string tag);
        logic [7:0]  r;
        logic [15:0] a;
        sel(); send_addr(8'h03, {8'h00, a0});
        for (int i = 0; i < nb; i++) begin
            xbyte(8'h00, r);
            a = a0 + 16'(i);
            check(tag, r, pat(a));
        end
        check({tag, " oe"}, miso_oe, 1'b1);
        desel();
        check({tag, " oe off"}, miso_oe, 1'b0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL R13 watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int base;
        bit lk;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1
        check("R1 oe", miso_oe, 0);
        check("R1 req", req_cnt, 0);
        check("R1 seq", seq_mode, 0);

        // R2 mode 0 read
        read_run(16'h1234, 4, "R2 read");
        // R3 wrap, R14 mode 3
        mode3 = 1'b1;
        read_run(16'hFFFE, 4, "R3 R14 wrap");
        mode3 = 1'b0;

        // R4 status repeat
        for (int k = 0; k < 2; k++) begin
            stat = (k == 0) ? 8'hA5 : 8'h5A;
            mode3 = (k == 1);
            sel(); xbyte(8'h05, r);
            for (int i = 0; i < 3; i++) begin xbyte(8'h00, r); check("R4 status", r, stat); end
            desel();
        end
        mode3 = 1'b0;

        // R5 ID alternation
        sel(); send_addr(8'h90, 24'h000000);
        for (int i = 0; i < 3; i++) begin xbyte(8'h00, r); check("R5 id0", r, (i % 2 == 0) ? 8'hBF : 8'h44); end
        desel();
        sel(); send_addr(8'hAB, 24'h000001);
        for (int i = 0; i < 2; i++) begin xbyte(8'h00, r); check("R5 id1", r, (i % 2 == 0) ? 8'h44 : 8'hBF); end
        desel();

        // R6 events
        cmd1(8'h06); check("R6 wr_on", n_on, 1);
        cmd1(8'h04); check("R6 wr_off", n_off, 1);
        cmd1(8'h50); check("R6 arm", n_arm, 1);
        cmd2(8'h01, 8'h9C); check("R6 stat_wr", n_swr, 1); check("R6 stat data", last_swr, 8'h9C);
        cmd2(8'h06, 8'h00); check("R6 long frame", n_on, 1);

        // R7 byte program
        wel = 1'b1; lvl = 2'd0;
        cmd_ad(8'h02, 24'h001357, 8'h6B); wait_done();
        check("R7 prog cnt", req_cnt, 1); check("R7 op", last_op, 0);
        check("R7 addr", last_addr, 16'h1357); check("R7 data", last_data, 8'h6B);
        wel = 1'b0;
        cmd_ad(8'h02, 24'h001358, 8'h6C); wait_done();
        check("R7 no wel", req_cnt, 1);
        wel = 1'b1;

        // R8 protection sweep
        for (int l = 0; l < 4; l++) begin
            for (int q = 0; q < 4; q++) begin
                lvl = 2'(l);
                base = req_cnt;
                cmd_ad(8'h02, 24'((q << 14) | 16'h0123), 8'h11); wait_done();
                lk = (l == 3) || (l == 2 && q >= 2) || (l == 1 && q == 3);
                check("R8 sweep", req_cnt - base, lk ? 0 : 1);
            end
        end
        lvl = 2'd1; base = req_cnt;
        cmd1(8'h60); wait_done();
        check("R8 chip locked", req_cnt - base, 0);
        lvl = 2'd0;
        cmd1(8'h60); wait_done();
        check("R8 chip", req_cnt - base, 1); check("R8 chip op", last_op, 3);

        // R9 erase alignment
        cmd_a(8'h20, 24'h005ABC); wait_done();
        check("R9 sector op", last_op, 1); check("R9 sector addr", last_addr, 16'h5000);
        cmd_a(8'h52, 24'h00DEAD); wait_done();
        check("R9 block op", last_op, 2); check("R9 block addr", last_addr, 16'h8000);

        // R10 sequential programming
        base = req_cnt;
        cmd_ad(8'hAF, 24'h000100, 8'h11); wait_done();
        check("R10 first", last_addr, 16'h0100); check("R10 mode", seq_mode, 1);
        cmd2(8'hAF, 8'h22); wait_done();
        check("R10 next addr", last_addr, 16'h0101); check("R10 next data", last_data, 8'h22);
        cmd1(8'h04);
        check("R10 wr_off ends", seq_mode, 0);
        cmd2(8'hAF, 8'h33); wait_done();
        check("R10 after end", req_cnt - base, 2);

        // R11 top of array
        cmd_ad(8'hAF, 24'h00FFFE, 8'h44); wait_done();
        cmd2(8'hAF, 8'h55); wait_done();
        check("R11 top addr", last_addr, 16'hFFFF);
        check("R11 end pulse", n_end, 1); check("R11 mode off", seq_mode, 0);
        base = req_cnt;
        cmd2(8'hAF, 8'h66); wait_done();
        check("R11 no wrap", req_cnt - base, 0);

        // R12 aborted frames
        sel(); xbits(8'h06, 7, r); desel();
        check("R12 partial op", n_on, 1);
        base = req_cnt;
        sel(); send_addr(8'h02, 24'h000400); xbits(8'hAA, 4, r); desel(); wait_done();
        check("R12 partial data", req_cnt - base, 0);

        // R13 busy
        lat = 3000;
        cmd_ad(8'h02, 24'h000200, 8'h77);
        check("R13 issued", req_cnt - base, 1);
        cmd1(8'h06);
        check("R13 ignored", n_on, 1);
        cmd_ad(8'h02, 24'h000201, 8'h78);
        check("R13 no second", req_cnt - base, 1);
        stat = 8'hC3;
        sel(); xbyte(8'h05, r); xbyte(8'h00, r); desel();
        check("R13 status ok", r, 8'hC3);
        repeat (3100) @(negedge clk);
        lat = 30;
        cmd1(8'h06);
        check("R13 after done", n_on, 2);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule